// File: doc/BRIEF.md
# Pulse-and-Verify One-Time-Programmable Word Programmer

This block drives the programming of a run of 16-bit words into a one-time-programmable array. After a start strobe it raises a margin-mode control and then works through each address from a first to a last address. For each word it requests the target value from a data source and reads the cell's present contents. It then applies fixed-length program pulses, with a read-back after every pulse, until the word matches or a retry limit is reached. All sixteen data bits are driven in parallel during a pulse.

After the last word the margin control is dropped. The whole range is then read back and compared in two separate passes, so that external supply control can set a different supply condition for each pass. Every duration (margin settle, address and data setup, pulse width, data hold, read settle) is given in nanoseconds and turned into clock cycles from a clock-frequency parameter. The block drives only the logic levels; it does not generate the high programming voltage.

Success raises `done_o`. Any failure raises `fail_o` and stores a reason code and the address of the word concerned. Both stay unchanged until the next accepted start.

Top module: `otp_burn_seq`

## Requirements
- R1: `margin_o` rises at least one setup time (1 µs) before any pulse and stays high for all programming. `pulse_o` is never high while `margin_o` is low. `margin_o` is low for at least 1 µs before the first check read and throughout both check passes.
- R2: Each program pulse is high for exactly round(50 µs × clock frequency) cycles. This lies inside the allowed 45–55 µs window.
- R3: `addr_o` and `wdata_o` are stable for at least 1 µs before a pulse rises. `addr_o` and `wdata_o` stay unchanged while the pulse is high. `wdata_o` is held for at least 2 µs after the pulse falls.
- R4: Every pulse is followed by a verify read. A mismatch leads to another pulse. A word still mismatching after its 25th pulse ends the run with `fail_code_o` = 2'b01 and `fail_addr_o` set to that word's address, after exactly 25 pulses on it.
- R5: A matching verify moves to the next address. After the last address the programming loop ends. A word whose cell already holds the requested value receives no pulse.
- R6: Before any pulse, the current cell value is read. If the requested word has a 1 where the cell holds a 0, the run ends with `fail_code_o` = 2'b10 and `fail_addr_o` set to that word's address, with no pulse on that word.
- R7: After programming, every word in the range is read and compared in pass 0 (`chk_pass_o` = 0) and then again in pass 1 (`chk_pass_o` = 1), once per word per pass. A mismatch ends the run with `fail_code_o` = 2'b11 and `fail_addr_o` set to that word's address.
- R8: A run with every word programmed and both passes matching ends with `done_o` = 1, `fail_o` = 0, `fail_code_o` = 2'b00, and `busy_o` low.
- R9: The read strobe `rd_en_o` stays high for exactly round(1 µs × clock frequency) cycles per read. Read data is sampled only at the end of that time.
- R10: `fail_o`, `fail_code_o` and `fail_addr_o` hold their values until the next accepted start strobe. That strobe clears them and `done_o`.
- R11: A start strobe while `busy_o` is high is ignored. The running job's range, pulses and result are unchanged.
- R12: After reset the block is idle: `busy_o`, `done_o`, `fail_o`, `pulse_o`, `margin_o`, `rd_en_o` and `src_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle, taken only when idle |
| first_addr_i | input | AW | First word address of the job |
| last_addr_i | input | AW | Last word address of the job (inclusive) |
| src_req_o | output | 1 | Requests the target word for index `addr_o` |
| src_ack_i | input | 1 | Data source answer strobe, `src_data_i` valid |
| src_data_i | input | 16 | Target word from the data source |
| rd_en_o | output | 1 | Read strobe to the array at `addr_o` |
| rd_data_i | input | 16 | Array read data |
| addr_o | output | AW | Word address to the array and index to the source |
| wdata_o | output | 16 | Word to program, all bits in parallel |
| pulse_o | output | 1 | Program pulse enable |
| margin_o | output | 1 | Margin-mode control |
| chk_pass_o | output | 1 | Current final check pass (0 or 1) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Last job ended successfully |
| fail_o | output | 1 | Last job failed |
| fail_code_o | output | 2 | Failure reason: 01 retry limit, 10 unprogrammable, 11 check mismatch |
| fail_addr_o | output | AW | Address of the failing word |

## Verification
The embedded properties check on every cycle four things: the exact pulse width and read-strobe width, the absence of pulses outside margin mode, and the setup, stability and hold windows of address and data around each pulse. They also check the per-word retry count bound, the timer's countdown, and that a failure result stays frozen while no start arrives. Whether the right number of pulses lands on each word, whether a word is skipped or flagged unprogrammable, whether both check passes visit every word, and whether a start during a run is really ignored are shown only by the bench's scenarios. These scenarios run against a behavioural array model whose cells need a chosen number of pulses.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        FC_NONE   = 2'b00,
        FC_LIMIT  = 2'b01,
        FC_UNPROG = 2'b10,
        FC_CHECK  = 2'b11
    } fail_code_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MARGIN_ON,
        S_FETCH,
        S_PRE_RD,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VERIFY,
        S_MARGIN_OFF,
        S_CFETCH,
        S_CRD
    } state_e;

    typedef struct packed {
        logic unprog;   // requested word needs a 0 -> 1 change
        logic match;    // cell equals requested word
    } cmp_t;

    // Rounded cycle count for a duration in ns, never below one cycle.
    function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd500_000_000) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/otp_burn_timer.sv
module otp_burn_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load_i)       cnt_q <= val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R2, R9: every timed window is an uninterrupted countdown
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/otp_burn_tries.sv
module otp_burn_tries #(
    parameter int unsigned MAX_TRIES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (inc_i)   cnt_q <= cnt_q + 1'b1;
    end

    // the pulse just verified is the last one allowed
    assign last_o = (cnt_q == CW'(MAX_TRIES - 1));

    // R4: retry count never runs past the limit
    p_tries_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_TRIES - 1));

endmodule

// File: rtl/otp_burn_cellcheck.sv
module otp_burn_cellcheck
    import otp_burn_pkg::*;
(
    input  word_t want_i,
    input  word_t cell_i,
    output cmp_t  cmp_o
);
    always_comb begin
        cmp_o.unprog = |(want_i & ~cell_i);
        cmp_o.match  = (want_i == cell_i);
    end
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
    import otp_burn_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned MAX_TRIES = 25,
    parameter int unsigned PULSE_NS  = 50_000,
    parameter int unsigned SETUP_NS  = 1_000,
    parameter int unsigned HOLD_NS   = 2_000,
    parameter int unsigned SETTLE_NS = 1_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] first_addr_i,
    input  logic [AW-1:0] last_addr_i,
    output logic          src_req_o,
    input  logic          src_ack_i,
    input  logic [15:0]   src_data_i,
    output logic          rd_en_o,
    input  logic [15:0]   rd_data_i,
    output logic [AW-1:0] addr_o,
    output logic [15:0]   wdata_o,
    output logic          pulse_o,
    output logic          margin_o,
    output logic          chk_pass_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          fail_o,
    output logic [1:0]    fail_code_o,
    output logic [AW-1:0] fail_addr_o
);
    localparam int unsigned PULSE_CYC  = ns_to_cyc(CLK_HZ, PULSE_NS);
    localparam int unsigned SETUP_CYC  = ns_to_cyc(CLK_HZ, SETUP_NS);
    localparam int unsigned HOLD_CYC   = ns_to_cyc(CLK_HZ, HOLD_NS);
    localparam int unsigned SETTLE_CYC = ns_to_cyc(CLK_HZ, SETTLE_NS);
    localparam int unsigned TMR_MAX    = max2(max2(PULSE_CYC, SETUP_CYC),
                                              max2(HOLD_CYC, SETTLE_CYC));
    localparam int unsigned TW         = $clog2(TMR_MAX + 1);

    state_e     st_q, st_d;
    logic [AW-1:0] addr_q, first_q, last_q, fail_addr_q;
    word_t      wdata_q;
    logic       pass_q, done_q, fail_q;
    fail_code_e code_q, fin_code;

    logic a_first, a_inc, a_wload, t_clr, t_inc, p_set, fin_ok, fin_fail;
    logic tmr_load, tmr_zero, tries_last, at_last, take_start;
    logic [TW-1:0] tmr_val;
    cmp_t cmp;

    assign at_last    = (addr_q == last_q);
    assign take_start = (st_q == S_IDLE) && start_i;

    otp_burn_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    otp_burn_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk(clk), .rst(rst), .clr_i(t_clr), .inc_i(t_inc), .last_o(tries_last)
    );

    otp_burn_cellcheck u_cmp (
        .want_i(wdata_q), .cell_i(rd_data_i), .cmp_o(cmp)
    );

    function automatic int unsigned state_cycles(state_e s);
        case (s)
            S_MARGIN_ON, S_MARGIN_OFF, S_SETUP: return SETUP_CYC;
            S_PULSE:                            return PULSE_CYC;
            S_HOLD:                             return HOLD_CYC;
            S_PRE_RD, S_VERIFY, S_CRD:          return SETTLE_CYC;
            default:                            return 1;
        endcase
    endfunction

    // next state and datapath actions
    always_comb begin
        st_d     = st_q;
        a_first  = 1'b0;
        a_inc    = 1'b0;
        a_wload  = 1'b0;
        t_clr    = 1'b0;
        t_inc    = 1'b0;
        p_set    = 1'b0;
        fin_ok   = 1'b0;
        fin_fail = 1'b0;
        fin_code = FC_NONE;
        case (st_q)
            S_IDLE:      if (start_i) st_d = S_MARGIN_ON;
            S_MARGIN_ON: if (tmr_zero) st_d = S_FETCH;
            S_FETCH: if (src_ack_i) begin
                a_wload = 1'b1;
                t_clr   = 1'b1;
                st_d    = S_PRE_RD;
            end
            S_PRE_RD: if (tmr_zero) begin
                if (cmp.unprog) begin
                    fin_fail = 1'b1;
                    fin_code = FC_UNPROG;
                    st_d     = S_IDLE;
                end else if (cmp.match) begin
                    if (at_last) st_d = S_MARGIN_OFF;
                    else begin a_inc = 1'b1; st_d = S_FETCH; end
                end else begin
                    st_d = S_SETUP;
                end
            end
            S_SETUP: if (tmr_zero) st_d = S_PULSE;
            S_PULSE: if (tmr_zero) st_d = S_HOLD;
            S_HOLD:  if (tmr_zero) st_d = S_VERIFY;
            S_VERIFY: if (tmr_zero) begin
                if (cmp.match) begin
                    if (at_last) st_d = S_MARGIN_OFF;
                    else begin a_inc = 1'b1; st_d = S_FETCH; end
                end else if (tries_last) begin
                    fin_fail = 1'b1;
                    fin_code = FC_LIMIT;
                    st_d     = S_IDLE;
                end else begin
                    t_inc = 1'b1;
                    st_d  = S_SETUP;
                end
            end
            S_MARGIN_OFF: if (tmr_zero) begin
                a_first = 1'b1;
                st_d    = S_CFETCH;
            end
            S_CFETCH: if (src_ack_i) begin
                a_wload = 1'b1;
                st_d    = S_CRD;
            end
            S_CRD: if (tmr_zero) begin
                if (!cmp.match) begin
                    fin_fail = 1'b1;
                    fin_code = FC_CHECK;
                    st_d     = S_IDLE;
                end else if (!at_last) begin
                    a_inc = 1'b1;
                    st_d  = S_CFETCH;
                end else if (pass_q) begin
                    fin_ok = 1'b1;
                    st_d   = S_IDLE;
                end else begin
                    p_set   = 1'b1;
                    a_first = 1'b1;
                    st_d    = S_CFETCH;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign tmr_load = (st_d != st_q);
    assign tmr_val  = TW'(state_cycles(st_d) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= S_IDLE;
            addr_q      <= '0;
            first_q     <= '0;
            last_q      <= '0;
            wdata_q     <= '0;
            pass_q      <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            code_q      <= FC_NONE;
            fail_addr_q <= '0;
        end else begin
            st_q <= st_d;
            if (take_start) begin
                first_q     <= first_addr_i;
                last_q      <= last_addr_i;
                addr_q      <= first_addr_i;
                pass_q      <= 1'b0;
                done_q      <= 1'b0;
                fail_q      <= 1'b0;
                code_q      <= FC_NONE;
                fail_addr_q <= '0;
            end
            if (a_first)  addr_q  <= first_q;
            if (a_inc)    addr_q  <= addr_q + 1'b1;
            if (a_wload)  wdata_q <= src_data_i;
            if (p_set)    pass_q  <= 1'b1;
            if (fin_ok)   done_q  <= 1'b1;
            if (fin_fail) begin
                fail_q      <= 1'b1;
                code_q      <= fin_code;
                fail_addr_q <= addr_q;
            end
        end
    end

    always_comb begin
        case (st_q)
            S_MARGIN_ON, S_FETCH, S_PRE_RD, S_SETUP,
            S_PULSE, S_HOLD, S_VERIFY: margin_o = 1'b1;
            default:                   margin_o = 1'b0;
        endcase
    end

    assign pulse_o     = (st_q == S_PULSE);
    assign rd_en_o     = (st_q == S_PRE_RD) || (st_q == S_VERIFY) || (st_q == S_CRD);
    assign src_req_o   = (st_q == S_FETCH) || (st_q == S_CFETCH);
    assign busy_o      = (st_q != S_IDLE);
    assign addr_o      = addr_q;
    assign wdata_o     = wdata_q;
    assign chk_pass_o  = pass_q;
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign fail_code_o = code_q;
    assign fail_addr_o = fail_addr_q;

    // ---------------- checker state for the timing properties ----------------
    logic [31:0] pulse_run, rd_run;
    logic [15:0] stab_run, since_fall;
    logic [AW-1:0] prev_addr;
    word_t prev_wd;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_run  <= '0;
            rd_run     <= '0;
            stab_run   <= '1;
            since_fall <= '1;
            prev_addr  <= '0;
            prev_wd    <= '0;
        end else begin
            pulse_run <= pulse_o ? pulse_run + 1 : '0;
            rd_run    <= rd_en_o ? rd_run + 1 : '0;
            prev_addr <= addr_o;
            prev_wd   <= wdata_o;
            if (addr_o != prev_addr || wdata_o != prev_wd) stab_run <= '0;
            else if (stab_run != '1)                         stab_run <= stab_run + 1'b1;
            if (pulse_o)                 since_fall <= '0;
            else if (since_fall != '1)   since_fall <= since_fall + 1'b1;
        end
    end

    p_pulse_in_margin_r1: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> margin_o);

    p_pulse_len_r2: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && pulse_run != 0) |-> (pulse_run == PULSE_CYC));

    p_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> (32'(stab_run) >= SETUP_CYC));

    p_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && $past(pulse_o)) |-> ($stable(addr_o) && $stable(wdata_o)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wdata_o != prev_wd) |-> (32'(since_fall) >= HOLD_CYC));

    p_rd_settle_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_o && rd_run != 0) |-> (rd_run == SETTLE_CYC));

    p_fail_held_r10: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_code_o)));

endmodule

// File: tb/sim_otp_burn_seq.sv
module sim_otp_burn_seq;
    // 2 MHz design clock parameter: 1 us = 2, 2 us = 4, 50 us = 100 cycles
    localparam int unsigned T_PULSE  = 100;
    localparam int unsigned T_SETUP  = 2;
    localparam int unsigned T_HOLD   = 4;
    localparam int unsigned T_SETTLE = 2;
    localparam int unsigned LIMIT    = 25;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0] first_a = '0, last_a = '0;
    logic src_req, src_ack = 1'b0, rd_en, pulse, margin, chk_pass, busy, done, fail;
    logic [15:0] src_data = '0, rd_data, wdata;
    logic [7:0] addr, fail_addr;
    logic [1:0] fail_code;

    always #10 clk = ~clk;   // 50 MHz

    otp_burn_seq #(.AW(8), .CLK_HZ(2_000_000)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .first_addr_i(first_a), .last_addr_i(last_a),
        .src_req_o(src_req), .src_ack_i(src_ack), .src_data_i(src_data),
        .rd_en_o(rd_en), .rd_data_i(rd_data), .addr_o(addr), .wdata_o(wdata),
        .pulse_o(pulse), .margin_o(margin), .chk_pass_o(chk_pass), .busy_o(busy),
        .done_o(done), .fail_o(fail), .fail_code_o(fail_code), .fail_addr_o(fail_addr)
    );

    function automatic logic [15:0] want(input logic [7:0] a);
        return 16'h5A3C ^ {a, ~a};
    endfunction

    // ---------------- array and data source model ----------------
    logic [15:0] cells [256];
    int          hits  [256];
    int          need = 1;
    logic wipe = 1'b0, pre_en = 1'b0, corrupt_arm = 1'b0, corrupt_done = 1'b0, pulse_q = 1'b0;
    logic [7:0] pre_a = '0, corrupt_a = '0;
    logic [15:0] pre_v = '0;

    assign rd_data = rd_en ? cells[addr] : 16'h0000;

    always @(posedge clk) begin
        pulse_q  <= pulse;
        src_ack  <= src_req && !src_ack;
        src_data <= want(addr);
        if (wipe) begin
            for (int i = 0; i < 256; i++) begin
                cells[i] <= 16'hFFFF;
                hits[i]  <= 0;
            end
            corrupt_done <= 1'b0;
        end else begin
            if (pre_en) cells[pre_a] <= pre_v;
            if (pulse_q && !pulse) begin
                hits[addr] <= hits[addr] + 1;
                if (hits[addr] + 1 >= need) cells[addr] <= cells[addr] & wdata;
            end
            if (corrupt_arm && !corrupt_done && chk_pass) begin
                cells[corrupt_a] <= cells[corrupt_a] ^ 16'h0100;
                corrupt_done     <= 1'b1;
            end
        end
    end

    // ---------------- timing monitors (sampled at negedge) ----------------
    int n_pulses = 0, pw_bad = 0, su_bad = 0, hd_bad = 0, mg_bad = 0, rd_bad = 0, c0 = 0, c1 = 0;
    int pw_run = 0, rd_run = 0, since_chg = 0, since_fall = 1000;
    logic p_prev = 1'b0, r_prev = 1'b0;
    logic [7:0] a_prev = '0;
    logic [15:0] w_prev = '0;

    always @(negedge clk) begin
        if (addr != a_prev || wdata != w_prev) since_chg = 0; else since_chg++;
        if (wdata != w_prev && since_fall < T_HOLD) hd_bad++;
        if (pulse && !p_prev) begin
            n_pulses++;
            if (since_chg < T_SETUP) su_bad++;
        end
        if (pulse) begin
            pw_run++;
            if (!margin) mg_bad++;
        end
        if (!pulse && p_prev) begin
            if (pw_run != T_PULSE) pw_bad++;
            pw_run = 0;
            since_fall = 0;
        end else if (!pulse) since_fall++;
        if (rd_en) rd_run++;
        if (rd_en && !r_prev && !margin) begin
            if (chk_pass) c1++; else c0++;
        end
        if (!rd_en && r_prev) begin
            if (rd_run != T_SETTLE) rd_bad++;
            rd_run = 0;
        end
        p_prev = pulse; r_prev = rd_en; a_prev = addr; w_prev = wdata;
    end

    // ---------------- bookkeeping ----------------
    int tests = 0, errors = 0;
    logic go_busy0, go_fail0;
    int s_pul, s_pw, s_su, s_hd, s_mg, s_rd, s_c0, s_c1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep(input int n);
        @(negedge clk);
        need = n; wipe = 1'b1; corrupt_arm = 1'b0;
        @(negedge clk);
        wipe = 1'b0;
    endtask

    task automatic preload(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk); pre_a = a; pre_v = v; pre_en = 1'b1;
        @(negedge clk); pre_en = 1'b0;
    endtask

    task automatic snap();
        s_pul = n_pulses; s_pw = pw_bad; s_su = su_bad; s_hd = hd_bad;
        s_mg = mg_bad; s_rd = rd_bad; s_c0 = c0; s_c1 = c1;
    endtask

    task automatic go(input logic [7:0] f, input logic [7:0] l);
        int n;
        snap();
        @(negedge clk); first_a = f; last_a = l; start = 1'b1;
        @(negedge clk); start = 1'b0;
        go_busy0 = busy; go_fail0 = fail;
        n = 0;
        while (busy && n < 60000) begin @(negedge clk); n++; end
    endtask

    task automatic timing_checks();
        check(mg_bad == s_mg, "R1 pulse outside margin", mg_bad - s_mg, 0);
        check(pw_bad == s_pw, "R2 pulse width errors", pw_bad - s_pw, 0);
        check(su_bad == s_su && hd_bad == s_hd, "R3 setup/hold errors",
              (su_bad - s_su) + (hd_bad - s_hd), 0);
        check(rd_bad == s_rd, "R9 read settle errors", rd_bad - s_rd, 0);
    endtask

    // stimulus/expectation table: first, last, pulses needed, code, total pulses
    localparam int NV = 5;
    localparam logic [7:0] V_FIRST [NV] = '{8'd0,  8'd10, 8'd20, 8'd30, 8'd40};
    localparam logic [7:0] V_LAST  [NV] = '{8'd3,  8'd10, 8'd22, 8'd31, 8'd42};
    localparam int         V_NEED  [NV] = '{1, 3, 24, 25, 26};
    localparam logic [1:0] V_CODE  [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b01};
    localparam int         V_PULS  [NV] = '{4, 3, 72, 50, 25};

    initial begin
        repeat (190000) @(posedge clk);
        tests++; errors++;
        $display("FAIL R8 watchdog expired: actual busy=%0d expected finished", busy);
        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check({busy, done, fail, pulse, margin, rd_en, src_req} == 7'b0, "R12 idle after reset",
              {busy, done, fail, pulse, margin, rd_en, src_req}, 0);

        // table-driven jobs: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            int words;
            words = int'(V_LAST[v]) - int'(V_FIRST[v]) + 1;
            prep(V_NEED[v]);
            go(V_FIRST[v], V_LAST[v]);
            check(fail_code == V_CODE[v], "R4 result code", fail_code, V_CODE[v]);
            check(n_pulses - s_pul == V_PULS[v], "R4 pulse count", n_pulses - s_pul, V_PULS[v]);
            timing_checks();
            if (V_CODE[v] == 2'b00) begin
                int bad;
                check(done && !fail && !busy, "R8 done flag", {done, fail, busy}, 3'b100);
                check(c0 - s_c0 == words && c1 - s_c1 == words, "R7 reads per pass",
                      (c0 - s_c0) * 1000 + (c1 - s_c1), words * 1001);
                bad = 0;
                for (int a = int'(V_FIRST[v]); a <= int'(V_LAST[v]); a++)
                    if (cells[a] != want(8'(a))) bad++;
                check(bad == 0, "R5 all words programmed", bad, 0);
            end else begin
                check(fail && !done && fail_addr == V_FIRST[v], "R4 limit fail address",
                      fail_addr, V_FIRST[v]);
                check(c0 - s_c0 == 0, "R4 no check after limit", c0 - s_c0, 0);
            end
        end

        // R5: word already holding its value gets no pulse
        prep(1);
        preload(8'd50, want(8'd50));
        go(8'd50, 8'd51);
        check(done && n_pulses - s_pul == 1, "R5 skip matching word", n_pulses - s_pul, 1);

        // R6: unprogrammable word (cell 0000, requested has 1s)
        prep(1);
        preload(8'd61, 16'h0000);
        go(8'd60, 8'd62);
        check(fail && fail_code == 2'b10, "R6 unprogrammable code", fail_code, 2'b10);
        check(fail_addr == 8'd61, "R6 fail address", fail_addr, 61);
        check(n_pulses - s_pul == 1, "R6 no pulse on flagged word", n_pulses - s_pul, 1);
        check(!margin && !busy, "R1 margin low after fail", margin, 0);

        // R10: failure stays latched while idle
        repeat (100) @(negedge clk);
        check(fail && fail_code == 2'b10 && fail_addr == 8'd61, "R10 fail held",
              {fail, fail_code, fail_addr}, {1'b1, 2'b10, 8'd61});

        // R7: corruption during pass 1 is caught; R10: start clears old failure
        prep(1);
        corrupt_a = 8'd71; corrupt_arm = 1'b1;
        go(8'd70, 8'd72);
        check(!go_fail0 && go_busy0, "R10 start clears fail", go_fail0, 0);
        check(fail && fail_code == 2'b11 && fail_addr == 8'd71, "R7 check mismatch",
              {fail_code, fail_addr}, {2'b11, 8'd71});
        check(c0 - s_c0 == 3 && c1 - s_c1 == 2, "R7 pass reads before mismatch",
              (c0 - s_c0) * 10 + (c1 - s_c1), 32);
        corrupt_arm = 1'b0;

        // R11: start while busy is ignored
        prep(1);
        snap();
        @(negedge clk); first_a = 8'd80; last_a = 8'd81; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (50) @(negedge clk);
        first_a = 8'd90; last_a = 8'd95; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy, "R11 still busy after ignored start", busy, 1);
        for (int n = 0; n < 60000 && busy; n++) @(negedge clk);
        check(done && !fail && n_pulses - s_pul == 2, "R11 original job result",
              n_pulses - s_pul, 2);
        check(cells[90] == 16'hFFFF && cells[81] == want(8'd81), "R11 second range untouched",
              cells[90], 16'hFFFF);

        $display("[TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end
endmodule